// File: doc/BRIEF.md
# Source-Routed Header Route Decoder

This block sits behind one input virtual channel of a wormhole router. When a header flit is presented it works out, from the route the sender wrote into the header, which output port the packet must take. It raises a one-hot request for that port and presents a forwarded copy of the header. The forwarded header has the hop's share of the route already consumed. Body and tail flits carry no route information. They are steered with the route captured when the header was accepted, and that route is kept until the tail flit has been taken.

The routing mode is fixed when the block is built. Two variants route along a two-dimensional mesh, moving in X before Y. In one the header holds absolute destination coordinates, which are compared with the router's own position. In the other it holds signed hop offsets, which are moved one step towards zero at every hop. The third variant follows a turn list and works on any topology. The first entry names the router where the packet must turn and the port it turns into. A router that finds its own address there takes that port and strips the entry. Any other router passes the packet straight on. Besides the four mesh ports, the router has a configurable number of local ports.

Top module: `route_decoder`

## Requirements
- R1: Bits [FW-1:FW-2] of a flit give its kind: 10 header, 00 body, 01 tail, 11 single-flit packet. A body or tail flit is requested to the port latched when its header was accepted (`in_valid && in_ready`), and passes to `out_flit` unchanged. While a flit is stalled with `in_ready` low, its request does not change.
- R2: Once a tail or single-flit packet is accepted, and after reset, no packet is open, and a body or tail flit raises no request.
- R3: In the mesh modes, a packet with a nonzero X distance goes to +X (port 0) or -X (port 1) whatever its Y distance. Only when X is settled does it go to +Y (port 2) or -Y (port 3).
- R4: In absolute mode, payload bits [CW-1:0] hold destination X and bits [2CW-1:CW] hold destination Y. These are compared unsigned with `node_id[CW-1:0]` (X) and `node_id[2CW-1:CW]` (Y). A larger destination selects the plus port. The header is forwarded unchanged.
- R5: In offset mode the same two fields hold two's-complement hop counts. The field of the dimension being travelled is moved one step towards zero in the forwarded header, and every other bit is kept.
- R6: In the mesh modes, with both dimensions settled, the packet goes to local port 4+L. L is the local index in payload bits [2CW+LW-1:2CW]. An index of NLOCAL or more raises no request.
- R7: In turn-list mode, entry 0 occupies payload bits [AW-1:0] for the address (AW = 2*CW) and [AW+PIW-1:AW] for the port code. If the address equals `node_id`, the request goes to that port, and the forwarded payload is shifted right by AW+PIW bits with zeros filled in at the top.
- R8: In turn-list mode, if the entry 0 address differs from `node_id`, the request goes to STRAIGHT_PORT and the header is forwarded unchanged.
- R9: In turn-list mode, a matching entry whose port code is NPORT or more raises no request.
- R10: `out_req` has at most one bit set, and it is all zeros whenever `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A flit is present on `in_flit` |
| in_ready | input | 1 | The switch takes the present flit this cycle |
| in_flit | input | FW | Flit: kind in the top two bits, payload below |
| node_id | input | 2*CW | This router's position ({Y,X}) or turn-list address |
| out_req | output | NPORT | One-hot output port request |
| out_flit | output | FW | Flit to forward, with the header rewritten |

## Verification
One build of each mode is exercised against a behavioural model. Tests include packets whose X and Y both differ: a decoder that settled Y first would send them to a Y port. Offsets at the extremes +7 and -8 are used as well: a wrong-way step or an overflow corrupts the forwarded X field. In turn-list mode, an entry with a foreign address must keep its header intact, and an invalid port code must raise nothing. A design that kept a stale route would steer a stray body flit after a tail. A design that latched on an unaccepted header, or dropped the route while stalled, would mis-steer the body flits that follow.

// File: rtl/route_pkg.sv
package route_pkg;

  // Build-time routing variants
  localparam int MODE_ABS    = 0;
  localparam int MODE_OFS    = 1;
  localparam int MODE_STREET = 2;

  // Output port numbering
  localparam int P_XP   = 0;
  localparam int P_XN   = 1;
  localparam int P_YP   = 2;
  localparam int P_YN   = 3;
  localparam int P_LOC0 = 4;

  typedef enum logic [1:0] {
    FK_BODY   = 2'b00,
    FK_TAIL   = 2'b01,
    FK_HEAD   = 2'b10,
    FK_SINGLE = 2'b11
  } flit_kind_e;

endpackage

// File: rtl/rdec_rst_sync.sv
module rdec_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/rdec_onehot.sv
module rdec_onehot #(
  parameter int IW    = 4,
  parameter int NPORT = 7
) (
  input  logic [IW-1:0]    idx,
  output logic [NPORT-1:0] oh
);

  // an index outside 0..NPORT-1 matches no port and yields all zeros
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign oh[p] = (idx == IW'(p));
  end

endmodule

// File: rtl/rdec_axis.sv
module rdec_axis #(
  parameter int CW     = 4,
  parameter bit OFFSET = 1'b0
) (
  input  logic signed [CW:0] delta,
  input  logic [CW-1:0]      field,
  output logic               pos,
  output logic               neg,
  output logic [CW-1:0]      next_field
);

  assign neg = delta[CW];
  assign pos = !delta[CW] && (delta != '0);

  if (OFFSET) begin : g_step
    // hop count moves one step towards zero
    always_comb begin
      if (pos)      next_field = field - CW'(1);
      else if (neg) next_field = field + CW'(1);
      else          next_field = field;
    end
  end else begin : g_keep
    assign next_field = field;
  end

endmodule

// File: rtl/rdec_street.sv
module rdec_street #(
  parameter int AW            = 8,
  parameter int PIW           = 3,
  parameter int PW            = 30,
  parameter int STRAIGHT_PORT = 0
) (
  input  logic [PW-1:0] pay,
  input  logic [AW-1:0] node,
  output logic [PIW:0]  port_idx,
  output logic [PW-1:0] next_pay
);

  localparam int EW = AW + PIW;
  localparam int IW = PIW + 1;

  logic hit;

  assign hit = (pay[AW-1:0] == node);

  always_comb begin
    if (hit) begin
      port_idx = {1'b0, pay[EW-1:AW]};
      next_pay = pay >> EW;
    end else begin
      port_idx = IW'(STRAIGHT_PORT);
      next_pay = pay;
    end
  end

endmodule

// File: rtl/route_decoder.sv
module route_decoder import route_pkg::*; #(
  parameter int FW            = 32,
  parameter int CW            = 4,
  parameter int NLOCAL        = 3,
  parameter int MODE          = MODE_STREET,
  parameter int STRAIGHT_PORT = P_XP,
  localparam int NPORT        = 4 + NLOCAL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_ready,
  input  logic [FW-1:0]    in_flit,
  input  logic [2*CW-1:0]  node_id,
  output logic [NPORT-1:0] out_req,
  output logic [FW-1:0]    out_flit
);

  localparam int PW  = FW - 2;
  localparam int AW  = 2 * CW;
  localparam int PIW = $clog2(NPORT);
  localparam int IW  = PIW + 1;

  logic             rst_q;
  flit_kind_e       kind;
  logic             is_head;
  logic             is_tail;
  logic             accept;
  logic [PW-1:0]    pay;
  logic [PW-1:0]    new_pay;
  logic [IW-1:0]    dec_idx;
  logic [NPORT-1:0] dec_oh;
  logic [NPORT-1:0] cur_req;
  logic [NPORT-1:0] route_q, route_d;
  logic             open_q, open_d;

  rdec_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_q)
  );

  assign kind    = flit_kind_e'(in_flit[FW-1:FW-2]);
  assign is_head = (kind == FK_HEAD) || (kind == FK_SINGLE);
  assign is_tail = (kind == FK_TAIL) || (kind == FK_SINGLE);
  assign pay     = in_flit[PW-1:0];
  assign accept  = in_valid && in_ready;

  if (MODE == MODE_STREET) begin : g_street
    rdec_street #(
      .AW            (AW),
      .PIW           (PIW),
      .PW            (PW),
      .STRAIGHT_PORT (STRAIGHT_PORT)
    ) u_street (
      .pay      (pay),
      .node     (node_id),
      .port_idx (dec_idx),
      .next_pay (new_pay)
    );
  end else begin : g_mesh
    localparam int LW = (NLOCAL > 1) ? $clog2(NLOCAL) : 1;

    logic [CW-1:0]    x_f, y_f, nx, ny;
    logic [LW-1:0]    loc_f;
    logic signed [CW:0] dx, dy;
    logic             xp, xn, yp, yn;

    assign x_f   = pay[CW-1:0];
    assign y_f   = pay[2*CW-1:CW];
    assign loc_f = pay[2*CW+LW-1:2*CW];

    if (MODE == MODE_OFS) begin : g_ofs
      assign dx = $signed({x_f[CW-1], x_f});
      assign dy = $signed({y_f[CW-1], y_f});
    end else begin : g_abs
      assign dx = $signed({1'b0, x_f}) - $signed({1'b0, node_id[CW-1:0]});
      assign dy = $signed({1'b0, y_f}) - $signed({1'b0, node_id[2*CW-1:CW]});
    end

    rdec_axis #(.CW(CW), .OFFSET(MODE == MODE_OFS)) u_ax_x (
      .delta      (dx),
      .field      (x_f),
      .pos        (xp),
      .neg        (xn),
      .next_field (nx)
    );

    rdec_axis #(.CW(CW), .OFFSET(MODE == MODE_OFS)) u_ax_y (
      .delta      (dy),
      .field      (y_f),
      .pos        (yp),
      .neg        (yn),
      .next_field (ny)
    );

    // X is settled before Y is touched
    always_comb begin
      if (xp)      dec_idx = IW'(P_XP);
      else if (xn) dec_idx = IW'(P_XN);
      else if (yp) dec_idx = IW'(P_YP);
      else if (yn) dec_idx = IW'(P_YN);
      else         dec_idx = IW'(P_LOC0) + IW'(loc_f);
    end

    assign new_pay = {pay[PW-1:2*CW], ((xp || xn) ? y_f : ny), nx};
  end

  rdec_onehot #(.IW(IW), .NPORT(NPORT)) u_oh (
    .idx (dec_idx),
    .oh  (dec_oh)
  );

  // request and forwarded flit
  always_comb begin
    if (is_head)     cur_req = dec_oh;
    else if (open_q) cur_req = route_q;
    else             cur_req = '0;
    out_req  = in_valid ? cur_req : '0;
    out_flit = is_head ? {in_flit[FW-1:FW-2], new_pay} : in_flit;
  end

  // next state of the packet route
  always_comb begin
    route_d = route_q;
    open_d  = open_q;
    if (is_tail) begin
      open_d = 1'b0;
    end else if (is_head) begin
      open_d  = 1'b1;
      route_d = dec_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      route_q <= '0;
      open_q  <= 1'b0;
    end else if (accept) begin
      route_q <= route_d;
      open_q  <= open_d;
    end
  end

endmodule

// File: rtl/route_decoder_chk.sv
module route_decoder_chk #(
  parameter int FW    = 32,
  parameter int NPORT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [FW-1:0]    in_flit,
  input logic [NPORT-1:0] out_req
);

  // R10
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_req));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (out_req == '0));

  // R1
  keep_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_flit[FW-2]) |=>
      (!(in_valid && !in_flit[FW-1]) || (out_req == $past(out_req))));

  // R1
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=>
      (!(in_valid && $stable(in_flit)) || $stable(out_req)));

  // R2
  tail_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_flit[FW-2]) |=>
      (!(in_valid && !in_flit[FW-1]) || (out_req == '0)));

endmodule

bind route_decoder route_decoder_chk #(.FW(FW), .NPORT(NPORT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_flit  (in_flit),
  .out_req  (out_req)
);

// File: tb/sim_route_decoder.sv
module sim_route_decoder;
  localparam int FW = 32;
  localparam int PW = 30;
  localparam int NPORT = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             v [3];
  logic             r [3];
  logic [FW-1:0]    fl [3];
  logic [7:0]       node [3];
  logic [NPORT-1:0] rq0, rq1, rq2;
  logic [FW-1:0]    of0, of1, of2;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit open_m [3];
  int lroute [3];

  route_decoder #(.MODE(2), .STRAIGHT_PORT(0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v[0]), .in_ready(r[0]), .in_flit(fl[0]),
    .node_id(node[0]), .out_req(rq0), .out_flit(of0));
  route_decoder #(.MODE(0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v[1]), .in_ready(r[1]), .in_flit(fl[1]),
    .node_id(node[1]), .out_req(rq1), .out_flit(of1));
  route_decoder #(.MODE(1)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(v[2]), .in_ready(r[2]), .in_flit(fl[2]),
    .node_id(node[2]), .out_req(rq2), .out_flit(of2));

  localparam logic [1:0] KH = 2'b10, KB = 2'b00, KT = 2'b01, KS = 2'b11;

  function automatic int sx4(logic [3:0] f);
    int t;
    t = int'(f);
    if (t > 7) t = t - 16;
    return t;
  endfunction

  function automatic int ref_port(int k, logic [PW-1:0] p);
    int dx, dy;
    if (k == 0) begin
      if (p[7:0] != 8'h35) return 0;
      return (int'(p[10:8]) < NPORT) ? int'(p[10:8]) : -1;
    end
    if (k == 1) begin
      dx = int'(p[3:0]) - 3;
      dy = int'(p[7:4]) - 5;
    end else begin
      dx = sx4(p[3:0]);
      dy = sx4(p[7:4]);
    end
    if (dx > 0) return 0;
    if (dx < 0) return 1;
    if (dy > 0) return 2;
    if (dy < 0) return 3;
    return (int'(p[9:8]) < 3) ? 4 + int'(p[9:8]) : -1;
  endfunction

  function automatic logic [PW-1:0] ref_pay(int k, logic [PW-1:0] p);
    logic [PW-1:0] q;
    int dx, dy;
    q = p;
    if (k == 0) begin
      if (p[7:0] == 8'h35) q = p >> 11;
    end else if (k == 2) begin
      dx = sx4(p[3:0]);
      dy = sx4(p[7:4]);
      if (dx != 0)     q[3:0] = 4'((dx > 0) ? dx - 1 : dx + 1);
      else if (dy != 0) q[7:4] = 4'((dy > 0) ? dy - 1 : dy + 1);
    end
    return q;
  endfunction

  function automatic logic [NPORT-1:0] oh(int port);
    logic [NPORT-1:0] m;
    m = '0;
    if (port >= 0) m[port] = 1'b1;
    return m;
  endfunction

  function automatic logic [PW-1:0] st(logic [7:0] a0, logic [2:0] d0, logic [7:0] a1, logic [2:0] d1);
    return {8'hA5, d1, a1, d0, a0};
  endfunction

  function automatic logic [PW-1:0] dm(logic [3:0] x, logic [3:0] y, logic [1:0] li);
    return {20'hABCDE, li, y, x};
  endfunction

  function automatic logic [NPORT-1:0] req_of(int i);
    return (i == 0) ? rq0 : (i == 1) ? rq1 : rq2;
  endfunction

  function automatic logic [FW-1:0] flit_of(int i);
    return (i == 0) ? of0 : (i == 1) ? of1 : of2;
  endfunction

  task automatic cyc(int k, bit vv, bit rr, logic [FW-1:0] f, string tag);
    for (int i = 0; i < 3; i++) begin
      v[i] = 1'b0; r[i] = 1'b1; fl[i] = '0;
    end
    v[k] = vv; r[k] = rr; fl[k] = f;
    #3;
    for (int i = 0; i < 3; i++) begin
      logic [NPORT-1:0] er;
      logic [FW-1:0]    ef;
      string            t;
      t = (i == k) ? tag : "R10";
      if (!v[i])            er = '0;
      else if (fl[i][FW-1]) er = oh(ref_port(i, fl[i][PW-1:0]));
      else                  er = open_m[i] ? oh(lroute[i]) : '0;
      checks++;
      if (req_of(i) !== er) begin
        errors++;
        $display("FAIL %s inst%0d out_req: got %b expected %b", t, i, req_of(i), er);
      end
      if (v[i]) begin
        ef = fl[i][FW-1] ? {fl[i][FW-1:FW-2], ref_pay(i, fl[i][PW-1:0])} : fl[i];
        checks++;
        if (flit_of(i) !== ef) begin
          errors++;
          $display("FAIL %s inst%0d out_flit: got %h expected %h", t, i, flit_of(i), ef);
        end
      end
    end
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      if (v[i] && r[i]) begin
        if (fl[i][FW-2]) open_m[i] = 1'b0;
        else if (fl[i][FW-1]) begin
          open_m[i] = 1'b1;
          lroute[i] = ref_port(i, fl[i][PW-1:0]);
        end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    node[0] = 8'h35; node[1] = 8'h53; node[2] = 8'h53;
    for (int i = 0; i < 3; i++) begin
      v[i] = 1'b0; r[i] = 1'b1; fl[i] = '0; open_m[i] = 1'b0; lroute[i] = -1;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state: idle quiet, stray body steered nowhere
    cyc(0, 0, 1, '0, "R10");
    cyc(0, 1, 1, {KB, 30'h1234567}, "R2");

    // turn list: hit, stall, body, tail
    cyc(0, 1, 0, {KH, st(8'h35, 3'd2, 8'h77, 3'd4)}, "R7");
    cyc(0, 1, 0, {KH, st(8'h35, 3'd2, 8'h77, 3'd4)}, "R1");
    cyc(0, 1, 1, {KH, st(8'h35, 3'd2, 8'h77, 3'd4)}, "R7");
    cyc(0, 1, 1, {KB, 30'h0ABCDEF}, "R1");
    cyc(0, 1, 0, {KB, 30'h0FEDCBA}, "R1");
    cyc(0, 1, 1, {KB, 30'h0FEDCBA}, "R1");
    cyc(0, 1, 1, {KT, 30'h3333333}, "R1");
    cyc(0, 1, 1, {KB, 30'h1111111}, "R2");
    cyc(0, 1, 1, {KS, st(8'h12, 3'd3, 8'h35, 3'd1)}, "R8");
    cyc(0, 1, 1, {KS, st(8'h35, 3'd7, 8'h00, 3'd0)}, "R9");
    cyc(0, 1, 1, {KH, st(8'h35, 3'd5, 8'h9C, 3'd3)}, "R7");
    cyc(0, 1, 1, {KT, 30'h2222222}, "R1");
    cyc(0, 1, 1, {KS, st(8'h35, 3'd6, 8'hFF, 3'd7)}, "R7");

    // absolute coordinates, node at x=3 y=5
    cyc(1, 1, 1, {KS, dm(4'd7, 4'd1, 2'd0)}, "R4");
    cyc(1, 1, 1, {KS, dm(4'd1, 4'd7, 2'd0)}, "R3");
    cyc(1, 1, 1, {KS, dm(4'd3, 4'd7, 2'd0)}, "R3");
    cyc(1, 1, 1, {KS, dm(4'd3, 4'd0, 2'd1)}, "R4");
    cyc(1, 1, 1, {KS, dm(4'd3, 4'd5, 2'd2)}, "R6");
    cyc(1, 1, 1, {KS, dm(4'd3, 4'd5, 2'd3)}, "R6");
    cyc(1, 1, 1, {KB, 30'h0C0FFEE}, "R2");
    cyc(1, 1, 1, {KH, dm(4'd15, 4'd5, 2'd0)}, "R4");
    cyc(1, 1, 1, {KB, 30'h0000001}, "R1");
    cyc(1, 1, 1, {KT, 30'h0000002}, "R1");

    // signed offsets
    cyc(2, 1, 1, {KS, dm(4'd2, 4'd0, 2'd0)}, "R5");
    cyc(2, 1, 1, {KS, dm(4'hD, 4'd3, 2'd0)}, "R3");
    cyc(2, 1, 1, {KS, dm(4'd0, 4'hF, 2'd0)}, "R5");
    cyc(2, 1, 1, {KS, dm(4'd0, 4'd1, 2'd2)}, "R5");
    cyc(2, 1, 1, {KS, dm(4'd0, 4'd0, 2'd1)}, "R6");
    cyc(2, 1, 1, {KS, dm(4'd7, 4'h8, 2'd0)}, "R5");
    cyc(2, 1, 1, {KH, dm(4'h8, 4'd2, 2'd0)}, "R5");
    cyc(2, 1, 1, {KB, 30'h0055AA5}, "R1");
    cyc(2, 1, 1, {KT, 30'h00AA55A}, "R1");
    cyc(2, 1, 1, {KT, 30'h00AA55A}, "R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule